// File: doc/BRIEF.md
# I2C Block-Access Configuration Slave

This block is a standard-mode I2C target that owns seven 8-bit configuration registers. The registers steer clock-generation controls elsewhere on the chip: the frequency select code, the choice between strapped and register-driven frequency, spread enable, output tristate, and the per-output enable masks. The bus pins are oversampled by the system clock, and the block pulls SDA low only through an open-drain output enable.

Only whole-block transfers exist. To write, the host sends the write address, a command byte and a count byte, and then data bytes. The block acknowledges the command and count bytes and discards them. The data bytes fill the registers from index 0 upward, and the host may stop after any complete byte. To read, the host sends the read address. The block then returns a count byte followed by every register in index order.

Top module: `i2c_blkcfg`

## Requirements
- R1: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged. Any other address byte gets no acknowledge, and the block leaves SDA released through every later byte until the next START.
- R2: In a write, the two bytes after the address (command, then count) are each acknowledged, and neither changes any register.
- R3: In a write, the third byte and each later byte is acknowledged. These bytes go to registers 0, 1, 2 and onward in order. A STOP after any complete byte keeps every byte written before it.
- R4: Register 6 is read-only and holds 0x06. A data byte aimed at it is acknowledged and dropped. Data bytes past register 6 are also acknowledged and dropped.
- R5: In a read, the block sends MSB first the byte count 7 and then registers 0 to 6, one byte after each host acknowledge. A host not-acknowledge ends the transmission, and SDA stays released.
- R6: After reset the registers are, in order 0 to 6: 0x00, 0x07, 0xBF, 0xFF, 0xFF, 0x0F, 0x06.
- R7: The decoded controls come from register 0. freqCode is {bit 2, bits 7:4}, with bit 2 as the MSB. freqFromReg is bit 3, spreadOn is bit 1 and outTristate is bit 0.
- R8: sdaOe high means SDA is pulled low. The block starts pulling SDA only while SCL is low.
- R9: A START at any point restarts address reception, and a repeated START may switch a write into a read. A STOP at any point returns the block to idle and drops any partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample SCL and SDA |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL level seen on the bus |
| sdaIn | input | 1 | SDA level seen on the bus |
| sdaOe | output | 1 | Pull SDA low when high |
| cfgRegs | output | 56 | Registers 0 to 6, register n in bits 8n+7:8n |
| freqCode | output | 5 | Frequency select code taken from register 0 |
| freqFromReg | output | 1 | Frequency comes from freqCode rather than straps |
| spreadOn | output | 1 | Spread modulation enable |
| outTristate | output | 1 | Tristate all clock outputs |

## Verification
Block writes are driven in several shapes: a full write that overruns past register 6, a write cut short after two data bytes, a write that holds only the command byte, and a write stopped in the middle of a data byte. These shapes separate a wrong byte-to-register mapping, a header byte that leaks into a register, a write to the read-only register, and a partial byte that gets committed. Reads are tried with a STOP before them and after a repeated START. Each read ends with a host not-acknowledge, which checks the count byte, the register order and the release of the bus. Foreign addresses followed by a further byte show whether the block stays off the bus. A behavioural register image is compared against every output on every clock.

// File: rtl/blkcfg_pkg.sv
package blkcfg_pkg;
  // strobes from the bus controller to the register datapath
  typedef struct packed {
    logic shiftIn;  // shift rxBit into the receive byte
    logic rxBit;    // sampled SDA
    logic clrIdx;   // restart the byte index
    logic incIdx;   // advance the byte index
    logic commit;   // write the receive byte to the indexed register
    logic loadTx;   // load the transmit byte for the current index
    logic shiftTx;  // move to the next transmit bit
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WDATA,
    ST_RDATA,
    ST_MACK
  } busState_t;
endpackage

// File: rtl/blkcfg_sync.sv
module blkcfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int PIPE_W = STAGES + 1;

  logic [PIPE_W-1:0] sclPipe;
  logic [PIPE_W-1:0] sdaPipe;
  logic sclS, sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE_W-2:0], sdaIn};
    end
  end

  assign sclS = sclPipe[STAGES-1];
  assign sclD = sclPipe[STAGES];
  assign sdaS = sdaPipe[STAGES-1];
  assign sdaD = sdaPipe[STAGES];

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
endmodule

// File: rtl/blkcfg_ctrl.sv
module blkcfg_ctrl
  import blkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaS,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [7:0] rxByte,
  output dpCtl_t     ctl,
  output logic       ackDrive,
  output logic       txEn
);
  busState_t state, stateNxt;
  logic [3:0] bitCnt, bitNxt;
  logic ackPhase, phNxt;
  logic isAddr, addrNxt;
  logic readMode, rdNxt;
  logic ackNxt, txNxt;

  always_comb begin
    stateNxt = state;
    bitNxt   = bitCnt;
    phNxt    = ackPhase;
    addrNxt  = isAddr;
    rdNxt    = readMode;
    ackNxt   = ackDrive;
    txNxt    = txEn;
    ctl      = '0;
    ctl.rxBit = sdaS;

    if (stopDet) begin
      stateNxt = ST_IDLE;
      ackNxt   = 1'b0;
      txNxt    = 1'b0;
    end else if (startDet) begin
      stateNxt = ST_ADDR;
      bitNxt   = '0;
      ackNxt   = 1'b0;
      txNxt    = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WDATA: begin
          if (sclRise) begin
            ctl.shiftIn = 1'b1;
            bitNxt = bitCnt + 4'd1;
            if (bitCnt == 4'd7) begin
              stateNxt = ST_ACK;
              phNxt    = 1'b0;
              addrNxt  = (state == ST_ADDR);
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            if (!ackPhase) begin
              if (isAddr && rxByte[7:1] != DEV_ADDR) begin
                stateNxt = ST_IDLE;
              end else begin
                ackNxt = 1'b1;
                phNxt  = 1'b1;
                if (isAddr) begin
                  rdNxt      = rxByte[0];
                  ctl.clrIdx = 1'b1;
                end else begin
                  ctl.commit = 1'b1;
                end
              end
            end else begin
              ackNxt = 1'b0;
              bitNxt = '0;
              if (readMode) begin
                ctl.loadTx = 1'b1;
                txNxt      = 1'b1;
                stateNxt   = ST_RDATA;
              end else begin
                ctl.incIdx = ~isAddr;
                stateNxt   = ST_WDATA;
              end
            end
          end
        end
        ST_RDATA: begin
          if (sclRise && bitCnt != 4'd8) begin
            bitNxt = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              txNxt    = 1'b0;
              phNxt    = 1'b0;
              stateNxt = ST_MACK;
            end else begin
              ctl.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            if (sdaS) begin
              stateNxt = ST_IDLE;
            end else begin
              ctl.incIdx = 1'b1;
              phNxt      = 1'b1;
            end
          end else if (sclFall && ackPhase) begin
            ctl.loadTx = 1'b1;
            txNxt      = 1'b1;
            bitNxt     = '0;
            stateNxt   = ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      isAddr   <= 1'b0;
      readMode <= 1'b0;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
    end else begin
      state    <= stateNxt;
      bitCnt   <= bitNxt;
      ackPhase <= phNxt;
      isAddr   <= addrNxt;
      readMode <= rdNxt;
      ackDrive <= ackNxt;
      txEn     <= txNxt;
    end
  end
endmodule

// File: rtl/blkcfg_regs.sv
module blkcfg_regs
  import blkcfg_pkg::*;
#(
  parameter int                          NUM_REGS     = 7,
  parameter int                          REG_W        = 8,
  parameter int                          HDR_BYTES    = 2,
  parameter logic [NUM_REGS*REG_W-1:0]   RESET_VALS   = 56'h06_0F_FF_FF_BF_07_00,
  parameter logic [NUM_REGS-1:0]         PROTECT_MASK = 7'b1000000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtl_t                    ctl,
  output logic [REG_W-1:0]          rxByte,
  output logic                      txMsb,
  output logic [NUM_REGS*REG_W-1:0] regsFlat
);
  localparam int IDX_W   = $clog2(NUM_REGS + HDR_BYTES + 2);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] shiftReg, txReg, txSrc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx      <= '0;
      shiftReg <= '0;
      txReg    <= '1;
    end else begin
      if (ctl.clrIdx)
        idx <= '0;
      else if (ctl.incIdx && idx != IDX_MAX)
        idx <= idx + 1'b1;
      if (ctl.shiftIn)
        shiftReg <= {shiftReg[REG_W-2:0], ctl.rxBit};
      if (ctl.loadTx)
        txReg <= txSrc;
      else if (ctl.shiftTx)
        txReg <= {txReg[REG_W-2:0], 1'b1};
    end
  end

  // read stream: count byte at index 0, then registers
  always_comb begin
    txSrc = '1;
    if (idx == '0)
      txSrc = REG_W'(NUM_REGS);
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i + 1))
        txSrc = regsFlat[i*REG_W +: REG_W];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam logic [REG_W-1:0] RST = RESET_VALS[g*REG_W +: REG_W];
    if (PROTECT_MASK[g]) begin : gRo
      assign regsFlat[g*REG_W +: REG_W] = RST;
    end else begin : gRw
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          q <= RST;
        else if (ctl.commit && idx == IDX_W'(HDR_BYTES + g))
          q <= shiftReg;
      end
      assign regsFlat[g*REG_W +: REG_W] = q;
    end
  end

  assign rxByte = shiftReg;
  assign txMsb  = txReg[REG_W-1];
endmodule

// File: rtl/i2c_blkcfg.sv
module i2c_blkcfg
  import blkcfg_pkg::*;
#(
  parameter logic [6:0]                DEV_ADDR     = 7'h69,
  parameter int                        NUM_REGS     = 7,
  parameter int                        REG_W        = 8,
  parameter int                        HDR_BYTES    = 2,
  parameter logic [NUM_REGS*REG_W-1:0] RESET_VALS   = 56'h06_0F_FF_FF_BF_07_00,
  parameter logic [NUM_REGS-1:0]       PROTECT_MASK = 7'b1000000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sclIn,
  input  logic                      sdaIn,
  output logic                      sdaOe,
  output logic [NUM_REGS*REG_W-1:0] cfgRegs,
  output logic [4:0]                freqCode,
  output logic                      freqFromReg,
  output logic                      spreadOn,
  output logic                      outTristate
);
  logic sdaS, sclRise, sclFall, startDet, stopDet;
  logic ackDrive, txEn, txMsb;
  logic [REG_W-1:0] rxByte;
  dpCtl_t ctl;

  blkcfg_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  blkcfg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .ctl(ctl), .ackDrive(ackDrive), .txEn(txEn)
  );

  blkcfg_regs #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .HDR_BYTES(HDR_BYTES),
    .RESET_VALS(RESET_VALS), .PROTECT_MASK(PROTECT_MASK)
  ) u_regs (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxByte(rxByte),
    .txMsb(txMsb), .regsFlat(cfgRegs)
  );

  assign sdaOe = ackDrive | (txEn & ~txMsb);

  // register 0 decode
  assign freqCode    = {cfgRegs[2], cfgRegs[7:4]};
  assign freqFromReg = cfgRegs[3];
  assign spreadOn    = cfgRegs[1];
  assign outTristate = cfgRegs[0];
endmodule

// File: rtl/blkcfg_chk.sv
module blkcfg_chk #(
  parameter int FLAT_W = 56
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic              sclFall,
  input logic              startDet,
  input logic              stopDet,
  input logic [FLAT_W-1:0] cfgRegs
);
  // R8
  sda_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  // R3
  cfg_change_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgRegs) |-> $past(sclFall));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

  // R9
  start_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe);
endmodule

bind i2c_blkcfg blkcfg_chk #(.FLAT_W(NUM_REGS*REG_W)) u_blkcfgChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
  .cfgRegs(cfgRegs)
);

// File: tb/test_i2c_blkcfg.sv
module test_i2c_blkcfg;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic [55:0] cfgRegs;
  logic [4:0] freqCode;
  logic freqFromReg, spreadOn, outTristate;
  logic sdaLine;

  int total = 0;
  int bad = 0;
  bit cmpEn = 1'b0;
  bit done = 1'b0;
  logic [7:0] mdl [7] = '{8'h00, 8'h07, 8'hBF, 8'hFF, 8'hFF, 8'h0F, 8'h06};

  always #2 clk = ~clk;

  assign sdaLine = sdaM & ~sdaOe;

  i2c_blkcfg i_i2c_blkcfg (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .cfgRegs(cfgRegs), .freqCode(freqCode), .freqFromReg(freqFromReg),
    .spreadOn(spreadOn), .outTristate(outTristate)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // reference image compared on every clock
  always @(negedge clk) begin
    if (rstN && cmpEn && !done) begin
      logic [55:0] expFlat;
      for (int i = 0; i < 7; i++) expFlat[i*8 +: 8] = mdl[i];
      chk("R3 R4 register image", int'(cfgRegs[31:0]), int'(expFlat[31:0]));
      chk("R3 R4 register image hi", int'(cfgRegs[55:32]), int'(expFlat[55:32]));
      chk("R7 decode", int'({freqCode, freqFromReg, spreadOn, outTristate}),
          int'({mdl[0][2], mdl[0][7:4], mdl[0][3], mdl[0][1], mdl[0][0]}));
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b0; waitClk(H);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b1; waitClk(H);
  endtask

  // wrIdx: register the byte targets in the model, -1 for none
  task automatic sendByte(input logic [7:0] b, input int wrIdx, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitClk(H);
      sclM = 1'b1; waitClk(H);
      sclM = 1'b0;
    end
    if (wrIdx >= 0) cmpEn = 1'b0;
    sdaM = 1'b1; waitClk(H);
    sclM = 1'b1; waitClk(H/2);
    acked = (sdaLine == 1'b0);
    if (wrIdx >= 0 && wrIdx < 6 && acked) mdl[wrIdx] = b;
    cmpEn = 1'b1;
    waitClk(H/2);
    sclM = 1'b0;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      waitClk(H);
      sclM = 1'b1; waitClk(H/2);
      b = {b[6:0], sdaLine};
      waitClk(H/2);
      sclM = 1'b0;
    end
    sdaM = ackIt ? 1'b0 : 1'b1; waitClk(H);
    sclM = 1'b1; waitClk(H);
    sclM = 1'b0;
    sdaM = 1'b1;
  endtask

  task automatic readAll();
    bit ack;
    logic [7:0] b;
    busStart();
    sendByte(8'hD3, -1, ack);
    chk("R1 read address ack", ack, 1);
    recvByte(1'b1, b);
    chk("R5 byte count", b, 7);
    for (int i = 0; i < 7; i++) begin
      recvByte(i != 6, b);
      chk("R5 read register", b, mdl[i]);
    end
    waitClk(H);
    chk("R5 released after nack", sdaOe, 0);
    busStop();
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    cmpEn = 1'b1;

    // R6 reset image
    chk("R6 reg0", cfgRegs[7:0], 8'h00);
    chk("R6 reg1", cfgRegs[15:8], 8'h07);
    chk("R6 reg2", cfgRegs[23:16], 8'hBF);
    chk("R6 reg5", cfgRegs[47:40], 8'h0F);
    chk("R6 reg6", cfgRegs[55:48], 8'h06);

    // full write that overruns past register 6
    busStart();
    sendByte(8'hD2, -1, ack); chk("R1 write address ack", ack, 1);
    sendByte(8'h3C, -1, ack); chk("R2 command ack", ack, 1);
    sendByte(8'h99, -1, ack); chk("R2 count ack", ack, 1);
    begin
      logic [7:0] data [9] = '{8'hB6, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'hA5, 8'hE7, 8'hE8};
      for (int i = 0; i < 9; i++) begin
        sendByte(data[i], i, ack);
        chk(i < 6 ? "R3 data ack" : "R4 dropped byte ack", ack, 1);
      end
    end
    busStop();
    chk("R3 reg0 written", cfgRegs[7:0], 8'hB6);
    chk("R4 reg6 kept", cfgRegs[55:48], 8'h06);
    chk("R7 freqCode", freqCode, 5'h1B);
    chk("R7 spreadOn", spreadOn, 1);

    readAll();

    // foreign addresses: no ack, stays off the bus
    busStart();
    sendByte(8'hA0, -1, ack); chk("R1 foreign address nack", ack, 0);
    sendByte(8'h00, -1, ack); chk("R1 released after foreign", ack, 0);
    busStop();
    busStart();
    sendByte(8'hD0, -1, ack); chk("R1 near address nack", ack, 0);
    busStop();

    // header only
    busStart();
    sendByte(8'hD2, -1, ack);
    sendByte(8'h4D, -1, ack); chk("R2 command ack", ack, 1);
    busStop();
    chk("R2 reg0 untouched", cfgRegs[7:0], 8'hB6);

    // short write
    busStart();
    sendByte(8'hD2, -1, ack);
    sendByte(8'h01, -1, ack);
    sendByte(8'h02, -1, ack);
    sendByte(8'h4D, 0, ack);
    sendByte(8'h66, 1, ack);
    busStop();
    chk("R3 short reg1", cfgRegs[15:8], 8'h66);
    chk("R3 short reg2 kept", cfgRegs[23:16], 8'h22);
    chk("R7 freqCode", freqCode, 5'h14);
    chk("R7 freqFromReg", freqFromReg, 1);
    chk("R7 outTristate", outTristate, 1);

    // stop inside a data byte
    busStart();
    sendByte(8'hD2, -1, ack);
    sendByte(8'h00, -1, ack);
    sendByte(8'h00, -1, ack);
    for (int i = 0; i < 3; i++) begin
      sdaM = 1'b1; waitClk(H);
      sclM = 1'b1; waitClk(H);
      sclM = 1'b0;
    end
    busStop();
    chk("R9 partial byte dropped", cfgRegs[7:0], 8'h4D);

    // repeated start from write into read
    busStart();
    sendByte(8'hD2, -1, ack);
    sendByte(8'h00, -1, ack);
    busStart();
    sendByte(8'hD3, -1, ack); chk("R9 restart read ack", ack, 1);
    recvByte(1'b1, b); chk("R9 restart count", b, 7);
    recvByte(1'b0, b); chk("R9 restart reg0", b, 8'h4D);
    waitClk(H);
    chk("R5 released after nack", sdaOe, 0);
    busStop();

    readAll();

    waitClk(10);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule